// File: doc/BRIEF.md
# Flash Charge Sequencer with Trigger Interlock

This block is the digital sequencer of a flash-capacitor charger. A level request from the host starts a charge cycle on its rising edge, provided the supply monitor reports a healthy supply at that moment. While a cycle runs, the block holds the switching converter enabled. When the output-target comparator trips, it stops the converter and pulls an active-low completion flag low. The flag stays latched until the host lowers the request. With the request low the block sits in standby: the converter is off and the flag is released.

The block also gates the flash-switch driver. Two trigger inputs are combined by AND into one firing command. Firing is blocked while a charge cycle is pending or running, so converter noise cannot fire the flash. Firing is allowed in standby and after completion. The two gate controls, one that pulls the gate up and one that pulls it down, are mutually exclusive. All inputs are treated as asynchronous and pass through synchronizer stages.

Top module: `flash_charge_sequencer`

## Requirements
- R1: After reset, charge_en_o is 0, done_n_o is 1, gate_src_o is 0 and gate_snk_o is 1.
- R2: A rising edge of req_i, seen while supply_ok_i is 1, sets charge_en_o to 1 within four clock cycles.
- R3: A rising edge of req_i seen while supply_ok_i is 0 starts no charge. A later return of supply_ok_i to 1 with req_i held high still starts no charge; only a new rising edge of req_i does.
- R4: When target_hit_i is 1 during a charge cycle, charge_en_o goes to 0 and done_n_o goes to 0. The two are never 1 and 0 respectively at the same time.
- R5: Once done_n_o is 0, it stays 0 for as long as req_i stays high, even after target_hit_i returns to 0.
- R6: While req_i is low (standby), charge_en_o is 0 and done_n_o is 1.
- R7: If supply_ok_i goes to 0 during a charge cycle, charge_en_o goes to 0 and done_n_o stays 1. Charging does not resume until req_i is lowered and raised again.
- R8: If supply loss and target_hit_i arrive in the same cycle during charging, supply loss takes priority: charge_en_o goes to 0 and done_n_o stays 1.
- R9: The firing command is the AND of trig_a_i and trig_b_i. When either trigger is 0, gate_src_o is 0.
- R10: Drive is enabled when req_i is low, or when req_i is high and done_n_o is 0. Drive is disabled when req_i is high and done_n_o is 1, including during charging. gate_src_o is 1 only when drive is enabled and the firing command is 1.
- R11: Exactly one of gate_src_o and gate_snk_o is 1 in every cycle. gate_snk_o is 1 whenever gate_src_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Charge request level (asynchronous) |
| supply_ok_i | input | 1 | 1 when the supply is above the undervoltage threshold (asynchronous) |
| target_hit_i | input | 1 | Output-target comparator, 1 when the target is reached (asynchronous) |
| trig_a_i | input | 1 | First trigger input (asynchronous) |
| trig_b_i | input | 1 | Second trigger input (asynchronous) |
| charge_en_o | output | 1 | Enable to the switching controller |
| done_n_o | output | 1 | Active-low charge-complete flag |
| gate_src_o | output | 1 | Gate pull-up enable for the flash switch |
| gate_snk_o | output | 1 | Gate pull-down enable for the flash switch |

## Verification
Two events can land on the same cycle in the sequencer: an undervoltage drop and a target-comparator trip during charging. The bench provokes this by changing supply_ok_i and target_hit_i in the same step, so both cross the synchronizers together. It then expects the abort path: converter off and the flag still high. Random steps also raise the request while the comparator is already high, and fire triggers across every state. A step-level model checks all four outputs once they have settled.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [1:0] {
        SEQ_STANDBY = 2'd0,
        SEQ_CHARGE  = 2'd1,
        SEQ_DONE    = 2'd2,
        SEQ_HOLD    = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       req_prev;
    } seq_regs_t;

    typedef struct packed {
        logic src;
        logic snk;
    } gate_regs_t;
endpackage

// File: rtl/fcs_sync.sv
module fcs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb chain_d[s] = async_i;
            end else begin : g_next
                always_comb chain_d[s] = chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/fcs_fsm.sv
module fcs_fsm
    import fcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic ok_s,
    input  logic hit_s,
    output logic charge_en,
    output logic done_n,
    output logic drive_en
);
    seq_regs_t r_d, r_q;
    logic      req_rise;

    always_comb begin
        r_d          = r_q;
        r_d.req_prev = req_s;
        req_rise     = req_s & ~r_q.req_prev;
        if (!req_s) begin
            r_d.state = SEQ_STANDBY;
        end else begin
            unique case (r_q.state)
                SEQ_STANDBY: begin
                    if (req_rise && ok_s) r_d.state = SEQ_CHARGE;
                    else                  r_d.state = SEQ_HOLD;
                end
                SEQ_CHARGE: begin
                    if (!ok_s)      r_d.state = SEQ_HOLD;   // supply loss wins over target hit
                    else if (hit_s) r_d.state = SEQ_DONE;
                end
                SEQ_DONE: r_d.state = SEQ_DONE;
                SEQ_HOLD: r_d.state = SEQ_HOLD;
                default:  r_d.state = SEQ_STANDBY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= SEQ_STANDBY;
            r_q.req_prev <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign charge_en = (r_q.state == SEQ_CHARGE);
    assign done_n    = (r_q.state != SEQ_DONE);
    assign drive_en  = (r_q.state == SEQ_STANDBY) || (r_q.state == SEQ_DONE);
endmodule

// File: rtl/fcs_gate.sv
module fcs_gate
    import fcs_pkg::*;
#(
    parameter int N_TRIG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drive_en,
    input  logic [N_TRIG-1:0] trig_s,
    output logic              gate_src,
    output logic              gate_snk
);
    gate_regs_t g_d, g_q;
    logic       fire;

    always_comb begin
        fire    = &trig_s;
        g_d.src = drive_en & fire;
        g_d.snk = ~(drive_en & fire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q.src <= 1'b0;
            g_q.snk <= 1'b1;
        end else begin
            g_q <= g_d;
        end
    end

    assign gate_src = g_q.src;
    assign gate_snk = g_q.snk;
endmodule

// File: rtl/flash_charge_sequencer.sv
module flash_charge_sequencer #(
    parameter int SYNC_STAGES = 2,
    parameter int N_TRIG      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic supply_ok_i,
    input  logic target_hit_i,
    input  logic trig_a_i,
    input  logic trig_b_i,
    output logic charge_en_o,
    output logic done_n_o,
    output logic gate_src_o,
    output logic gate_snk_o
);
    localparam int N_CTRL = 3;
    localparam int N_IN   = N_CTRL + N_TRIG;

    logic [N_IN-1:0]   raw_in, sync_in;
    logic              req_sync, ok_sync, hit_sync, drive_en;
    logic [N_TRIG-1:0] trig_sync;

    assign raw_in    = {trig_b_i, trig_a_i, target_hit_i, supply_ok_i, req_i};
    assign req_sync  = sync_in[0];
    assign ok_sync   = sync_in[1];
    assign hit_sync  = sync_in[2];
    assign trig_sync = sync_in[N_IN-1:N_CTRL];

    fcs_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    fcs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_s     (req_sync),
        .ok_s      (ok_sync),
        .hit_s     (hit_sync),
        .charge_en (charge_en_o),
        .done_n    (done_n_o),
        .drive_en  (drive_en)
    );

    fcs_gate #(.N_TRIG(N_TRIG)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .drive_en (drive_en),
        .trig_s   (trig_sync),
        .gate_src (gate_src_o),
        .gate_snk (gate_snk_o)
    );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
    input logic clk,
    input logic rst_n,
    input logic req_s,
    input logic ok_s,
    input logic charge_en,
    input logic done_n,
    input logic gate_src,
    input logic gate_snk
);
    assert_gate_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({gate_src, gate_snk}));

    assert_no_charge_when_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(charge_en && !done_n));

    assert_flag_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_n && req_s) |=> !done_n);

    assert_start_needs_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(charge_en) |-> $past(ok_s));

    assert_supply_loss_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (charge_en && !ok_s) |=> (!charge_en && done_n));

    assert_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_s |=> (!charge_en && done_n));

    assert_fire_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(charge_en) |-> !gate_src);
endmodule

bind flash_charge_sequencer fcs_checker u_fcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_s     (req_sync),
    .ok_s      (ok_sync),
    .charge_en (charge_en_o),
    .done_n    (done_n_o),
    .gate_src  (gate_src_o),
    .gate_snk  (gate_snk_o)
);

// File: tb/flash_charge_sequencer_test.sv
module flash_charge_sequencer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, ok = 1'b0, hit = 1'b0, ta = 1'b0, tb = 1'b0;
    logic charge_en, done_n, gsrc, gsnk;
    int   checks = 0;
    int   errors = 0;
    int   m_st = 0;   // 0 standby, 1 charge, 2 done, 3 hold
    bit   finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    flash_charge_sequencer uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .supply_ok_i(ok),
        .target_hit_i(hit), .trig_a_i(ta), .trig_b_i(tb),
        .charge_en_o(charge_en), .done_n_o(done_n),
        .gate_src_o(gsrc), .gate_snk_o(gsnk)
    );

    function automatic int next_st(int st, bit rq, bit k, bit h);
        if (!rq) return 0;
        case (st)
            0: return k ? (h ? 2 : 1) : 3;
            1: return !k ? 3 : (h ? 2 : 1);
            default: return st;
        endcase
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic step(input bit rq, input bit k, input bit h, input bit a, input bit b,
                        input string tag);
        bit en_exp, src_exp;
        @(negedge clk);
        req = rq; ok = k; hit = h; ta = a; tb = b;
        m_st = next_st(m_st, rq, k, h);
        repeat (7) @(negedge clk);
        en_exp  = (m_st == 0) || (m_st == 2);
        src_exp = en_exp && a && b;
        chk({tag, " charge_en"}, charge_en, (m_st == 1));
        chk({tag, " done_n"}, done_n, (m_st != 2));
        chk({tag, " gate_src R9/R10"}, gsrc, src_exp);
        chk({tag, " gate_snk R11"}, gsnk, !src_exp);
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 charge_en", charge_en, 1'b0);
        chk("R1 done_n", done_n, 1'b1);
        chk("R1 gate_src", gsrc, 1'b0);
        chk("R1 gate_snk", gsnk, 1'b1);
        rst_n = 1'b1;

        step(0, 1, 0, 1, 1, "R10 standby fires");
        step(1, 1, 0, 0, 0, "R2 start");
        step(1, 1, 0, 1, 1, "R10 blocked while charging");
        step(1, 1, 1, 1, 1, "R4 target hit, R10 fire after done");
        step(1, 1, 0, 1, 0, "R5 flag held, R9 one trigger");
        step(1, 1, 0, 0, 1, "R9 other trigger only");
        step(0, 1, 0, 0, 0, "R6 standby");
        step(1, 0, 0, 1, 1, "R3 rise under UV, R10 hold blocks");
        step(1, 1, 0, 0, 0, "R3 supply recovers no start");
        step(0, 1, 0, 0, 0, "R6 standby again");
        step(1, 1, 0, 0, 0, "R2 new edge starts");
        step(1, 0, 0, 0, 0, "R7 supply loss aborts");
        step(1, 1, 0, 0, 0, "R7 no resume");
        step(0, 1, 0, 0, 0, "R6 release");
        step(1, 1, 0, 0, 0, "R2 restart");
        step(1, 0, 1, 0, 0, "R8 loss and hit together");
        step(0, 1, 1, 0, 0, "R6 standby with hit high");
        step(1, 1, 1, 1, 1, "R4 rise with hit high");

        for (int i = 0; i < 400; i++) begin
            bit rq, k, h;
            rq = ($urandom % 4 != 0) ? req : ~req;
            k  = ($urandom % 6 != 0);
            h  = ($urandom % 3 == 0);
            step(rq, k, h, ($urandom % 2 == 1), ($urandom % 2 == 1),
                 "random R2/R4/R7/R10");
        end
        finish_run();
    end
endmodule